// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Delayed Write Data

This block is a synchronous static memory core for use inside a larger design. Address, control and lane-select inputs are registered on the rising clock edge. Read data leaves the array combinationally from the registered address, so a read issued at one edge is on the bus during the cycle that follows. Write data comes one cycle after its address, in the same bus slot that a read's data would use. Because of this, a read and a write may follow each other on every enabled clock with no idle cycle between them.

Each word is split into byte lanes. Every lane holds a data byte plus one parity bit, which is stored as given and is never generated. A write waits in a one-entry write registry until the next enabled edge moves it into the array. A read that targets the registry address gets the pending lanes merged over the array word.

The core also has:
- a stall input that freezes the core;
- three synchronous chip selects;
- a two-bit burst sequencer with linear or interleaved order;
- an asynchronous output enable;
- a sleep input that refuses new operations.

Top module: `ft_sram`

## Requirements
- R1: Address and control inputs are sampled on the rising edge. The word read from the address captured at edge N is on `dq_out`, with `dq_drv` high, during the cycle after edge N.
- R2: While `clk_en` is low, an edge changes nothing. The outputs hold their values, and any operation presented at that edge is not performed.
- R3: A read may follow a write on the very next enabled edge. A read of the address whose data was just sampled returns that new data.
- R4: `lane_wr_n[i]` low selects lane i for a write. Lane i is bits [9i+8:9i], and bit 9i+8 is its parity bit. Unselected lanes keep their contents, both on the bypass path and in the array.
- R5: An operation is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0 at a load edge. Any other combination is a deselect: nothing is written and `dq_drv` is low in the next cycle. A burst advance after a deselect also stays deselected.
- R6: In the data cycle of any write, `dq_drv` is low whatever the level of `oe_n`.
- R7: When `adv`=1, the previous operation continues at the next beat. The op type and upper address are held, and the byte-lane selects are sampled afresh at each beat. With `lin_order`=1 at the load edge, the low two address bits are (start + k) mod 4 for beat k.
- R8: With `lin_order`=0 at the load edge, the low two address bits of beat k are start XOR k.
- R9: `oe_n` high forces `dq_drv` low at once, with no clock edge needed.
- R10: With `sleep` high at an enabled edge, no operation is accepted. A write is not performed, and `dq_drv` is low in the following cycle.
- R11: Synchronous reset clears any operation in flight and drops a write whose data had not yet been sampled. Array contents are kept.
- R12: Write data is sampled at the edge after the write address. The value on `dq_in` during the address cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock qualifier; low stalls the core |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write when low, read when high (load edges only) |
| adv | input | 1 | 1 = advance burst, 0 = load a new operation |
| lin_order | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| dq_in | input | LANES*(LANE_DW+1) | Write data, sampled one edge after the address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request; refuses new operations |
| dq_out | output | LANES*(LANE_DW+1) | Flow-through read data |
| dq_drv | output | 1 | High when the core should drive the data bus |

## Verification
A write registry holding a wrong valid flag, address or lane mask shows up at `dq_out` in the very next cycle, if a read of the same address follows the write. One cycle later it shows up again, when the array copy is read back. A slip in the burst counter or a wrong order mode appears as a word read from the wrong location, in the cycle after the affected beat. A bad stall or sleep gate changes `dq_out` or `dq_drv` one cycle after the offending edge.

// File: rtl/ftsram_pkg.sv
`timescale 1ns/1ps
package ftsram_pkg;
  // low two address bits of burst beat `step` starting at `first`
  function automatic logic [1:0] burst_lo(input logic [1:0] first,
                                          input logic [1:0] step,
                                          input logic       linear);
    logic [1:0] sum;
    sum = first + step;
    return linear ? sum : (first ^ step);
  endfunction
endpackage

// File: rtl/ftsram_seq.sv
`timescale 1ns/1ps
// Operation register and burst address sequencer
module ftsram_seq #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              sel,
  input  logic              wr_n,
  input  logic              adv,
  input  logic              lin,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_n,
  output logic              op_vld,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LANES-1:0]  op_mask
);
  import ftsram_pkg::*;
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q;
  logic [1:0]      cnt_q;
  logic            lin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_vld  <= 1'b0;
      op_wr   <= 1'b0;
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      lin_q   <= 1'b1;
      op_mask <= '0;
    end else if (clk_en) begin
      op_mask <= ~lane_n;
      if (adv) begin
        op_vld <= op_vld & ~sleep;
        cnt_q  <= cnt_q + 2'd1;
      end else begin
        op_vld  <= sel & ~sleep;
        op_wr   <= ~wr_n;
        hi_q    <= addr[ADDR_W-1:2];
        start_q <= addr[1:0];
        cnt_q   <= '0;
        lin_q   <= lin;
      end
    end
  end

  assign op_addr = {hi_q, burst_lo(start_q, cnt_q, lin_q)};
endmodule

// File: rtl/ftsram_array.sv
`timescale 1ns/1ps
// Lane-writable storage, registered write port, read from a registered address
module ftsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wmask,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ftsram_wreg.sv
`timescale 1ns/1ps
// One-entry write registry with lane-wise read bypass
module ftsram_wreg #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en,
  input  logic                    op_vld,
  input  logic                    op_wr,
  input  logic [ADDR_W-1:0]       op_addr,
  input  logic [LANES-1:0]        op_mask,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES*LANE_W-1:0] arr_word,
  output logic                    cm_we,
  output logic [ADDR_W-1:0]       cm_addr,
  output logic [LANES*LANE_W-1:0] cm_data,
  output logic [LANES-1:0]        cm_mask,
  output logic [LANES*LANE_W-1:0] rd_word
);
  logic wv;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst)         wv <= 1'b0;
    else if (clk_en) wv <= op_vld & op_wr;
  end

  always_ff @(posedge clk) begin
    if (clk_en) begin
      cm_addr <= op_addr;
      cm_data <= din;
      cm_mask <= op_mask;
    end
  end

  assign cm_we = clk_en & wv;
  assign hit   = wv && (cm_addr == op_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LANE_W +: LANE_W] = (hit && cm_mask[g]) ? cm_data[g*LANE_W +: LANE_W]
                                                             : arr_word[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ft_sram.sv
`timescale 1ns/1ps
// Flow-through synchronous SRAM core with delayed write data phase
module ft_sram #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int LANE_DW = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             clk_en,
  input  logic                             cs_a_n,
  input  logic                             cs_b,
  input  logic                             cs_c_n,
  input  logic                             wr_n,
  input  logic                             adv,
  input  logic                             lin_order,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [LANES-1:0]                 lane_wr_n,
  input  logic [LANES*(LANE_DW+1)-1:0]     dq_in,
  input  logic                             oe_n,
  input  logic                             sleep,
  output logic [LANES*(LANE_DW+1)-1:0]     dq_out,
  output logic                             dq_drv
);
  localparam int LANE_W = LANE_DW + 1;
  localparam int DW     = LANES * LANE_W;

  logic              sel;
  logic              op_vld, op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  op_mask;
  logic              cm_we;
  logic [ADDR_W-1:0] cm_addr;
  logic [DW-1:0]     cm_data;
  logic [LANES-1:0]  cm_mask;
  logic [DW-1:0]     arr_word;

  assign sel = ~cs_a_n & cs_b & ~cs_c_n;

  ftsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sel(sel), .wr_n(wr_n), .adv(adv),
    .lin(lin_order), .sleep(sleep), .addr(addr), .lane_n(lane_wr_n),
    .op_vld(op_vld), .op_wr(op_wr), .op_addr(op_addr), .op_mask(op_mask)
  );

  ftsram_wreg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wreg (
    .clk(clk), .rst(rst), .clk_en(clk_en), .op_vld(op_vld), .op_wr(op_wr),
    .op_addr(op_addr), .op_mask(op_mask), .din(dq_in), .arr_word(arr_word),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data), .cm_mask(cm_mask),
    .rd_word(dq_out)
  );

  ftsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wdata(cm_data), .wmask(cm_mask),
    .raddr(op_addr), .rdata(arr_word)
  );

  assign dq_drv = op_vld & ~op_wr & ~oe_n;
endmodule

// File: rtl/ftsram_chk.sv
`timescale 1ns/1ps
module ftsram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en,
  input logic          cs_a_n,
  input logic          cs_b,
  input logic          cs_c_n,
  input logic          wr_n,
  input logic          adv,
  input logic          sleep,
  input logic [DW-1:0] dq_out,
  input logic          dq_drv
);
  logic chosen;
  assign chosen = (cs_a_n == 1'b0) && (cs_b == 1'b1) && (cs_c_n == 1'b0);

  assert_deselect_hiz_R5: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv && !chosen) |=> !dq_drv);

  assert_write_phase_hiz_R6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv && chosen && !wr_n) |=> !dq_drv);

  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(dq_out));

  assert_sleep_refuses_R10: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sleep) |=> !dq_drv);
endmodule

bind ft_sram ftsram_chk #(.DW(LANES*(LANE_DW+1))) u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .cs_a_n(cs_a_n), .cs_b(cs_b),
  .cs_c_n(cs_c_n), .wr_n(wr_n), .adv(adv), .sleep(sleep),
  .dq_out(dq_out), .dq_drv(dq_drv)
);

// File: tb/tb_ft_sram.sv
`timescale 1ns/1ps
module tb_ft_sram;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en = 1'b1, cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
  logic wr_n = 1'b1, adv = 1'b0, lin_order = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    lane_wr_n = 2'b00;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_drv;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ft_sram dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .wr_n(wr_n), .adv(adv), .lin_order(lin_order), .addr(addr),
    .lane_wr_n(lane_wr_n), .dq_in(dq_in), .oe_n(oe_n), .sleep(sleep),
    .dq_out(dq_out), .dq_drv(dq_drv)
  );

  typedef struct packed {
    logic          en;
    logic [2:0]    cs;     // {cs_a_n, cs_b, cs_c_n}; 3'b010 selects
    logic          wn;
    logic          ad;
    logic          ln;
    logic [AW-1:0] a;
    logic [1:0]    lw;
    logic [DW-1:0] d;
    logic          oe;
    logic          sl;
    logic          xdrv;
    logic [DW-1:0] xd;
    logic [4:0]    req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b1,3'b010,1'b0,1'b0,1'b1,6'h04,2'b00,18'h3FFFF,1'b0,1'b0,1'b0,18'h00000,5'd6},  // R6 write A4
    '{1'b1,3'b010,1'b0,1'b0,1'b1,6'h05,2'b00,18'h2A5C3,1'b0,1'b0,1'b0,18'h00000,5'd6},  // R6 write A5, data A4
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h05,2'b00,18'h15A3C,1'b0,1'b0,1'b1,18'h15A3C,5'd3},  // R3 bypass
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h04,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h2A5C3,5'd12}, // R12 R1
    '{1'b1,3'b010,1'b0,1'b0,1'b1,6'h05,2'b10,18'h00000,1'b0,1'b0,1'b0,18'h00000,5'd6},  // R6 lane0 write
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h05,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h15A00,5'd4},  // R4 merged
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h05,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h15A00,5'd4},  // R4 array
    '{1'b1,3'b000,1'b0,1'b0,1'b1,6'h04,2'b00,18'h00000,1'b0,1'b0,1'b0,18'h00000,5'd5},  // R5 deselect
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h04,2'b00,18'h3FFFF,1'b0,1'b0,1'b1,18'h2A5C3,5'd5},  // R5 no write
    '{1'b0,3'b010,1'b0,1'b0,1'b1,6'h04,2'b00,18'h3FFFF,1'b0,1'b0,1'b1,18'h2A5C3,5'd2},  // R2 stall
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h04,2'b00,18'h3FFFF,1'b0,1'b0,1'b1,18'h2A5C3,5'd2},  // R2 write dropped
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h04,2'b00,18'h00000,1'b1,1'b0,1'b0,18'h00000,5'd9},  // R9
    '{1'b1,3'b010,1'b0,1'b0,1'b1,6'h04,2'b00,18'h00000,1'b0,1'b1,1'b0,18'h00000,5'd10}, // R10 sleep
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h04,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h2A5C3,5'd10}, // R10 kept
    '{1'b1,3'b010,1'b0,1'b0,1'b1,6'h0A,2'b00,18'h00000,1'b0,1'b0,1'b0,18'h00000,5'd7},  // R7 linear load
    '{1'b1,3'b010,1'b1,1'b1,1'b1,6'h00,2'b00,18'h00011,1'b0,1'b0,1'b0,18'h00000,5'd7},
    '{1'b1,3'b010,1'b1,1'b1,1'b1,6'h00,2'b00,18'h00022,1'b0,1'b0,1'b0,18'h00000,5'd7},
    '{1'b1,3'b010,1'b1,1'b1,1'b1,6'h00,2'b00,18'h00033,1'b0,1'b0,1'b0,18'h00000,5'd7},
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h08,2'b00,18'h00044,1'b0,1'b0,1'b1,18'h00033,5'd7},  // R7
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h09,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00044,5'd7},
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h0A,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00011,5'd7},
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h0B,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00022,5'd7},
    '{1'b1,3'b010,1'b0,1'b0,1'b0,6'h0D,2'b00,18'h00000,1'b0,1'b0,1'b0,18'h00000,5'd8},  // R8 interleaved
    '{1'b1,3'b010,1'b1,1'b1,1'b1,6'h00,2'b00,18'h00101,1'b0,1'b0,1'b0,18'h00000,5'd8},
    '{1'b1,3'b010,1'b1,1'b1,1'b1,6'h00,2'b00,18'h00202,1'b0,1'b0,1'b0,18'h00000,5'd8},
    '{1'b1,3'b010,1'b1,1'b1,1'b1,6'h00,2'b00,18'h00303,1'b0,1'b0,1'b0,18'h00000,5'd8},
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h0C,2'b00,18'h00404,1'b0,1'b0,1'b1,18'h00202,5'd8},  // R8
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h0E,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00404,5'd8},
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h0F,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00303,5'd8},
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h0D,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00101,5'd8},
    '{1'b1,3'b010,1'b1,1'b0,1'b1,6'h0D,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00101,5'd7},  // R7 read burst
    '{1'b1,3'b010,1'b0,1'b1,1'b0,6'h00,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00404,5'd7},
    '{1'b1,3'b010,1'b0,1'b1,1'b0,6'h00,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00303,5'd7},
    '{1'b1,3'b010,1'b0,1'b1,1'b0,6'h00,2'b00,18'h00000,1'b0,1'b0,1'b1,18'h00202,5'd7},
    '{1'b1,3'b110,1'b1,1'b0,1'b1,6'h00,2'b00,18'h00000,1'b0,1'b0,1'b0,18'h00000,5'd5},  // R5
    '{1'b1,3'b010,1'b1,1'b1,1'b1,6'h00,2'b00,18'h00000,1'b0,1'b0,1'b0,18'h00000,5'd5}   // R5 adv stays off
  };

  task automatic check_out(input int req, input logic xdrv, input logic [DW-1:0] xd);
    checks++;
    if (dq_drv !== xdrv || (xdrv && dq_out !== xd)) begin
      fails++;
      $display("FAIL R%0d: drv=%b data=%h expected drv=%b data=%h", req, dq_drv, dq_out, xdrv, xd);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check_out(11, 1'b0, '0);   // R11 reset state
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clk_en = VEC[i].en; {cs_a_n, cs_b, cs_c_n} = VEC[i].cs;
      wr_n = VEC[i].wn; adv = VEC[i].ad; lin_order = VEC[i].ln;
      addr = VEC[i].a; lane_wr_n = VEC[i].lw; dq_in = VEC[i].d;
      oe_n = VEC[i].oe; sleep = VEC[i].sl;
      @(posedge clk);
      #2 check_out(int'(VEC[i].req), VEC[i].xdrv, VEC[i].xd);
    end

    // R11: reset during a write's data phase drops it
    @(negedge clk);
    {cs_a_n, cs_b, cs_c_n} = 3'b010; wr_n = 1'b0; adv = 1'b0; addr = 6'h04; dq_in = '0;
    @(negedge clk);
    rst = 1'b1; wr_n = 1'b1; {cs_a_n, cs_b, cs_c_n} = 3'b000;
    @(posedge clk);
    #2 check_out(11, 1'b0, '0);
    @(negedge clk);
    rst = 1'b0; {cs_a_n, cs_b, cs_c_n} = 3'b010; wr_n = 1'b1; addr = 6'h04; dq_in = 18'h3FFFF;
    @(posedge clk);
    #2 check_out(11, 1'b1, 18'h2A5C3);
    // R9: output enable acts without a clock edge; R1 read still on the bus
    oe_n = 1'b1;
    #1 check_out(9, 1'b0, '0);
    oe_n = 1'b0;
    #1 check_out(1, 1'b1, 18'h2A5C3);

    report();
    $finish;
  end
endmodule